// File: doc/BRIEF.md
# Flash Program Launch Sequencer

This block guards the start of a flash programming operation behind a two-write unlock. Software writes a control register through a simple CPU register-write port. The first write carries key 5h and only arms the sequencer. The second write must carry key Ah, and no other retired instruction may come between the two writes. The second write also carries a 2-bit mode that selects the target space. When the sequence holds and the mode names a real space, the block sends a one-cycle start request and a space code to the latch/program engine. It then holds a busy bit until the engine returns a done pulse.

The same register also holds a latch-map bit. While that bit is set, CPU external-data writes are steered to the column latches. The block's only job for this bit is to store it and drive it out. An instruction-boundary input pulses once for each retired instruction. The key write itself retires, so it produces one pulse. A second pulse means another instruction ran, and that cancels the armed state. Masking interrupts is left to software.

Top module: `flash_launch_seq`

## Requirements
- R1: After reset the sequencer is disarmed, `busy`, `eng_start` and `latch_map` are 0, and a read of the control address returns 00h.
- R2: Every write to the control address stores data bit 3 as the map bit and data bits [1:0] as the mode. The map bit drives `latch_map`. A read returns {4'b0, map, busy, mode}. The key is data bits [7:4].
- R3: A control write with key 5h arms the sequencer and by itself produces no start request.
- R4: An armed sequencer that receives a control write with key Ah and mode 00, 01 or 10 raises `eng_start` for exactly one cycle, in the cycle after that write. `eng_space` then equals the mode: 00 user, 01 extra row, 10 fuse bits.
- R5: A valid 5h/Ah sequence that carries mode 11 produces no start request and leaves `busy` at 0.
- R6: Retire pulses are counted only in cycles after the arming write. Once RET_LIMIT pulses (2 by default) have been seen while armed, the armed state is cleared and a following Ah write launches nothing. With fewer pulses the launch still happens.
- R7: An Ah write without a preceding 5h launches nothing. A control write with any key other than 5h or Ah disarms the sequencer.
- R8: `busy` rises together with `eng_start` and stays high until `eng_done` is sampled high. It is low from the next cycle on.
- R9: Key writes that arrive while `busy` is high are ignored. They neither launch nor arm, so after done an Ah write alone launches nothing.
- R10: Writes to any address other than the control address affect neither the armed state nor the outputs.
- R11: `eng_space` keeps its launch value for the whole busy period, even if the mode field is rewritten during that time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | ADDR_W | Register address of the CPU access |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data: key [7:4], map [3], mode [1:0] |
| reg_rdata | output | 8 | Read data of the control register, 0 at other addresses |
| insn_ret | input | 1 | One pulse for each retired instruction |
| eng_done | input | 1 | Engine finished programming |
| eng_start | output | 1 | One-cycle start request to the engine |
| eng_space | output | 2 | Target space of the current operation |
| latch_map | output | 1 | Steers external-data writes to the column latches |
| busy | output | 1 | Programming in progress |

## Verification
The bench builds the block with its default parameters: an 8-bit address, control address D1h and a retire limit of 2. With a retire limit of 2, sweeping zero to three retire pulses between the two key writes covers both sides of the abort threshold. Every mode, including the reserved one, is crossed with both map-bit values, so each launch and no-launch outcome is reached. Directed sequences then cover key writes while busy, stray keys, orphan Ah writes and writes to a foreign address.

// File: rtl/fls_pkg.sv
package fls_pkg;
  typedef enum logic [1:0] {
    SPACE_USER = 2'b00,
    SPACE_XROW = 2'b01,
    SPACE_FUSE = 2'b10,
    SPACE_NONE = 2'b11
  } space_e;

  typedef struct packed {
    logic [3:0] key;
    logic       map;
    logic       rsvd;
    logic [1:0] mode;
  } ctrl_wr_t;

  // a mode names a programmable space unless it is the reserved code
  function automatic logic space_is_live(input logic [1:0] mode);
    return mode != SPACE_NONE;
  endfunction

  // readback image of the control register
  function automatic logic [7:0] pack_status(input logic map, input logic bsy,
                                             input logic [1:0] mode);
    return {4'b0000, map, bsy, mode};
  endfunction
endpackage

// File: rtl/fls_key_arm.sv
module fls_key_arm #(
  parameter logic [3:0] KEY_ARM   = 4'h5,
  parameter logic [3:0] KEY_GO    = 4'hA,
  parameter int         RET_LIMIT = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       key_wr,
  input  logic [3:0] key,
  input  logic       insn_ret,
  input  logic       hold,
  output logic       armed,
  output logic       arm_evt,
  output logic       go_evt,
  output logic       abort_evt
);
  localparam int CNT_W = $clog2(RET_LIMIT + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(RET_LIMIT - 1);

  logic [CNT_W-1:0] ret_cnt;
  logic             key_take;

  assign key_take  = key_wr && !hold;
  assign arm_evt   = key_take && (key == KEY_ARM);
  assign go_evt    = key_take && armed && (key == KEY_GO);
  assign abort_evt = !key_take && armed && insn_ret && (ret_cnt == CNT_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed   <= 1'b0;
      ret_cnt <= '0;
    end else if (key_take) begin
      armed   <= (key == KEY_ARM);
      ret_cnt <= '0;
    end else if (abort_evt) begin
      armed   <= 1'b0;
      ret_cnt <= '0;
    end else if (armed && insn_ret) begin
      ret_cnt <= ret_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/fls_space_dec.sv
module fls_space_dec #(
  parameter int MODE_W = 2
) (
  input  logic              go_evt,
  input  logic [MODE_W-1:0] mode,
  output logic              launch_req,
  output logic [MODE_W-1:0] req_space
);
  import fls_pkg::*;
  localparam int NUM_CODES = 1 << MODE_W;

  logic [NUM_CODES-1:0] hit;

  for (genvar i = 0; i < NUM_CODES; i++) begin : g_code
    assign hit[i] = go_evt && (mode == MODE_W'(i)) && space_is_live(2'(i));
  end

  assign launch_req = |hit;
  assign req_space  = mode;
endmodule

// File: rtl/fls_busy_trk.sv
module fls_busy_trk #(
  parameter int MODE_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch_req,
  input  logic [MODE_W-1:0] req_space,
  input  logic              eng_done,
  output logic              busy,
  output logic              eng_start,
  output logic [MODE_W-1:0] eng_space
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      eng_start <= 1'b0;
      eng_space <= '0;
    end else begin
      eng_start <= launch_req && !busy;
      if (launch_req && !busy) begin
        busy      <= 1'b1;
        eng_space <= req_space;
      end else if (busy && eng_done) begin
        busy <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/flash_launch_seq.sv
module flash_launch_seq #(
  parameter int              ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'hD1,
  parameter int              RET_LIMIT = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic              insn_ret,
  input  logic              eng_done,
  output logic              eng_start,
  output logic [1:0]        eng_space,
  output logic              latch_map,
  output logic              busy
);
  import fls_pkg::*;

  ctrl_wr_t   wr_fields;
  logic       ctrl_sel;
  logic       ctrl_wr;
  logic       map_q;
  logic [1:0] mode_q;
  logic       armed;
  logic       arm_evt;
  logic       go_evt;
  logic       abort_evt;
  logic       launch_req;
  logic [1:0] req_space;

  assign wr_fields = ctrl_wr_t'(reg_wdata);
  assign ctrl_sel  = (reg_addr == CTRL_ADDR);
  assign ctrl_wr   = reg_wr && ctrl_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      map_q  <= 1'b0;
      mode_q <= 2'b00;
    end else if (ctrl_wr) begin
      map_q  <= wr_fields.map;
      mode_q <= wr_fields.mode;
    end
  end

  fls_key_arm #(
    .KEY_ARM  (4'h5),
    .KEY_GO   (4'hA),
    .RET_LIMIT(RET_LIMIT)
  ) u_key (
    .clk      (clk),
    .rst_n    (rst_n),
    .key_wr   (ctrl_wr),
    .key      (wr_fields.key),
    .insn_ret (insn_ret),
    .hold     (busy),
    .armed    (armed),
    .arm_evt  (arm_evt),
    .go_evt   (go_evt),
    .abort_evt(abort_evt)
  );

  fls_space_dec #(.MODE_W(2)) u_dec (
    .go_evt    (go_evt),
    .mode      (wr_fields.mode),
    .launch_req(launch_req),
    .req_space (req_space)
  );

  fls_busy_trk #(.MODE_W(2)) u_busy (
    .clk       (clk),
    .rst_n     (rst_n),
    .launch_req(launch_req),
    .req_space (req_space),
    .eng_done  (eng_done),
    .busy      (busy),
    .eng_start (eng_start),
    .eng_space (eng_space)
  );

  assign latch_map = map_q;
  assign reg_rdata = ctrl_sel ? pack_status(map_q, busy, mode_q) : 8'h00;
endmodule

// File: rtl/fls_launch_chk.sv
module fls_launch_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       eng_start,
  input logic       busy,
  input logic       eng_done,
  input logic [1:0] eng_space,
  input logic       armed,
  input logic       arm_evt
);
  // R4
  start_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |=> !eng_start);
  // R8
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |-> busy);
  // R8
  busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> eng_start);
  // R8
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !eng_done) |=> busy);
  // R8
  busy_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && eng_done) |=> !busy);
  // R5
  no_reserved_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |-> (eng_space != 2'b11));
  // R3
  arm_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arm_evt |=> (armed && !eng_start));
  // R9
  busy_disarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !armed);
  // R11
  space_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !eng_start) |-> $stable(eng_space));
endmodule

bind flash_launch_seq fls_launch_chk u_launch_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .eng_start(eng_start),
  .busy     (busy),
  .eng_done (eng_done),
  .eng_space(eng_space),
  .armed    (armed),
  .arm_evt  (arm_evt)
);

// File: tb/test_flash_launch_seq.sv
`timescale 1ns/1ps
module test_flash_launch_seq;
  localparam logic [7:0] CTRL = 8'hD1;
  localparam int LIMIT = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] reg_addr = CTRL;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       insn_ret = 1'b0;
  logic       eng_done = 1'b0;
  logic       eng_start;
  logic [1:0] eng_space;
  logic       latch_map;
  logic       busy;

  int vectors = 0;
  int miscompares = 0;

  always #2 clk = ~clk;

  flash_launch_seq i_flash_launch_seq (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .insn_ret(insn_ret),
    .eng_done(eng_done), .eng_start(eng_start), .eng_space(eng_space),
    .latch_map(latch_map), .busy(busy)
  );

  task automatic chk(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] ctl(input logic [3:0] key, input logic map,
                                     input logic [1:0] mode);
    return {key, map, 1'b0, mode};
  endfunction

  task automatic wr(input logic [7:0] addr, input logic [7:0] data);
    @(negedge clk);
    reg_addr = addr; reg_wdata = data; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; reg_addr = CTRL;
  endtask

  task automatic ret_pulses(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); insn_ret = 1'b1;
      @(negedge clk); insn_ret = 1'b0;
    end
  endtask

  task automatic finish_op();
    @(negedge clk); eng_done = 1'b1;
    @(negedge clk); eng_done = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 busy", busy, 0);
    chk("R1 start", eng_start, 0);
    chk("R1 map", latch_map, 0);
    chk("R1 rdata", reg_rdata, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 rdata after release", reg_rdata, 8'h00);

    // R2 R3 R4 R5 R6 sweep over mode, map and retire pulses
    for (int m = 0; m < 4; m++) begin
      for (int p = 0; p < 4; p++) begin
        logic mp;
        bit launch;
        mp = p[0];
        launch = (m != 3) && (p < LIMIT);
        wr(CTRL, ctl(4'h5, mp, 2'(m)));
        chk("R3 no start on arm", eng_start, 0);
        chk("R2 map stored", latch_map, mp);
        ret_pulses(p);
        wr(CTRL, ctl(4'hA, mp, 2'(m)));
        chk("R4/R5/R6 start", eng_start, launch);
        chk("R8 busy with start", busy, launch);
        chk("R2 readback", reg_rdata, {4'b0, mp, launch, 2'(m)});
        if (launch) begin
          chk("R4 space", eng_space, m);
          repeat (3) @(negedge clk);
          chk("R4 single pulse", eng_start, 0);
          chk("R8 busy held", busy, 1);
          chk("R11 space held", eng_space, m);
          finish_op();
          chk("R8 busy cleared", busy, 0);
        end else begin
          @(negedge clk);
          chk("R5/R6 still idle", busy, 0);
        end
      end
    end

    // R9 writes while busy ignored, R11 space kept
    wr(CTRL, ctl(4'h5, 1'b0, 2'b00));
    wr(CTRL, ctl(4'hA, 1'b0, 2'b00));
    chk("R9 launch", eng_start, 1);
    wr(CTRL, ctl(4'h5, 1'b0, 2'b01));
    wr(CTRL, ctl(4'hA, 1'b0, 2'b01));
    chk("R9 ignored while busy", eng_start, 0);
    chk("R11 space kept", eng_space, 0);
    chk("R2 mode rewritten", reg_rdata, 8'h05);
    finish_op();
    wr(CTRL, ctl(4'hA, 1'b0, 2'b01));
    chk("R9 no arm carried", eng_start, 0);
    chk("R9 idle", busy, 0);

    // R7 orphan go key, stray key disarms
    wr(CTRL, ctl(4'hA, 1'b0, 2'b10));
    chk("R7 orphan go", eng_start, 0);
    wr(CTRL, ctl(4'h5, 1'b0, 2'b10));
    wr(CTRL, ctl(4'h3, 1'b0, 2'b10));
    wr(CTRL, ctl(4'hA, 1'b0, 2'b10));
    chk("R7 stray key disarms", eng_start, 0);
    chk("R7 idle", busy, 0);

    // R10 foreign address ignored
    wr(CTRL, ctl(4'h5, 1'b1, 2'b01));
    wr(8'h42, ctl(4'hA, 1'b0, 2'b10));
    chk("R10 foreign no start", eng_start, 0);
    chk("R10 map kept", latch_map, 1);
    @(negedge clk); reg_addr = 8'h42; #0.5;
    chk("R10 foreign read", reg_rdata, 8'h00);
    reg_addr = CTRL;
    wr(CTRL, ctl(4'hA, 1'b1, 2'b01));
    chk("R10 still armed", eng_start, 1);
    chk("R10 space", eng_space, 1);
    finish_op();
    chk("R8 done", busy, 0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule